// File: doc/BRIEF.md
# Wash Drum Direction Sequencer

This block decides which way the wash drum motor turns during a wash program. Once the wash controller raises its run enable, the drum turns forward, rests, turns in reverse and rests again. That four-step cycle repeats while the wash timer is still running. When the timer reports that it has expired, the motor stops and the block stays stopped until run is withdrawn. Each step has its own length, counted in whole seconds from a one-cycle tick pulse. The tick is derived elsewhere from the 50 MHz system clock. The defaults are 20 s forward, 10 s rest, 20 s reverse and 10 s rest.

The block drives separate forward and reverse motor commands. It also drives three lamps for forward, reverse and pause. The minute countdown, the display and the end-of-wash sounder all sit outside the block. It sees them only as the run enable and the expired flag. Every step length is a parameter, so a test setup can shorten the cycle. A lamp-polarity option chooses between active-high and active-low lamp drive.

Top module: `wash_drum_sequencer`

## Requirements
- R1: While the active-low reset is held, both motor commands and all three lamps are low, and the block is idle.
- R2: When run_en is high and the expired flag is low while idle, the block enters the forward step on the next clock edge. The first forward step then lasts exactly FWD_SECS tick pulses.
- R3: The steps run in the order forward, first pause, reverse, second pause. They last exactly FWD_SECS, PAUSE_A_SECS, REV_SECS and PAUSE_B_SECS ticks. On the tick that completes a step, the next step begins at that clock edge.
- R4: The tick that completes the second pause returns the block to the forward step, and the cycle repeats.
- R5: motor_fwd and motor_rev are never high together. Both are low in the pause steps, while idle and while halted.
- R6: While a step is running, exactly one lamp is lit: lamp_fwd in forward, lamp_rev in reverse and lamp_pause in either pause. No lamp is lit while idle or halted. The lamp-to-motor match is motor_fwd with lamp_fwd and motor_rev with lamp_rev.
- R7: If timer_done is high while run_en is high, the block halts on that clock edge with all outputs low. This holds in every step, and the halt wins over a step boundary that falls in the same cycle. The block stays halted even if timer_done later falls, until run_en goes low.
- R8: When run_en is low, the block returns to idle on the next edge and clears its second count. A later start, or a release from reset, begins with a full forward step.
- R9: The second count advances only on tick cycles. Cycles without a tick leave the outputs unchanged. Ticks that arrive while idle or halted have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| run_en | input | 1 | Wash program running, from the wash controller |
| timer_done | input | 1 | Wash timer has expired |
| motor_fwd | output | 1 | Drum forward command |
| motor_rev | output | 1 | Drum reverse command |
| lamp_fwd | output | 1 | Forward lamp (polarity per LAMP_ACTIVE_LOW) |
| lamp_rev | output | 1 | Reverse lamp (polarity per LAMP_ACTIVE_LOW) |
| lamp_pause | output | 1 | Pause lamp (polarity per LAMP_ACTIVE_LOW) |

## Verification
A step boundary and a timer expiry can land on the same clock edge. The same is true of a step boundary and the withdrawal of run. The bench provokes both cases by raising the last tick of the second pause together with timer_done, and by dropping run_en on the tick that ends a forward step. It expects all outputs low after that edge, with no new step shown. For the expiry case it then clears the flag and sends further ticks, and judges that the block stays halted until run falls.

// File: rtl/wds_pkg.sv
package wds_pkg;

   typedef enum logic [2:0] {
      PH_IDLE    = 3'd0,
      PH_FWD     = 3'd1,
      PH_PAUSE_A = 3'd2,
      PH_REV     = 3'd3,
      PH_PAUSE_B = 3'd4,
      PH_HALT    = 3'd5
   } phase_e;

   // true for the four timed steps of the cycle
   function automatic logic phase_timed(input phase_e p);
      return (p == PH_FWD) || (p == PH_PAUSE_A) ||
             (p == PH_REV) || (p == PH_PAUSE_B);
   endfunction

   // step that follows a completed timed step
   function automatic phase_e phase_after(input phase_e p);
      case (p)
         PH_FWD:     return PH_PAUSE_A;
         PH_PAUSE_A: return PH_REV;
         PH_REV:     return PH_PAUSE_B;
         PH_PAUSE_B: return PH_FWD;
         default:    return p;
      endcase
   endfunction

endpackage

// File: rtl/wds_sec_counter.sv
module wds_sec_counter #(
   parameter int CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          tick,
   input  logic [CW-1:0] limit,
   output logic          last
);

   logic [CW-1:0] secs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         secs_q <= '0;
      else if (clear)
         secs_q <= '0;
      else if (tick)
         secs_q <= secs_q + CW'(1);
   end

   // the current tick is the final second of the step
   assign last = (secs_q == (limit - CW'(1)));

endmodule

// File: rtl/wds_phase_fsm.sv
module wds_phase_fsm
   import wds_pkg::*;
#(
   parameter int CW           = 5,
   parameter int FWD_SECS     = 20,
   parameter int PAUSE_A_SECS = 10,
   parameter int REV_SECS     = 20,
   parameter int PAUSE_B_SECS = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_en,
   input  logic          timer_done,
   input  logic          sec_tick,
   input  logic          sec_last,
   output phase_e        phase,
   output logic          cnt_clear,
   output logic [CW-1:0] limit
);

   phase_e phase_q, phase_d;
   logic   timed;
   logic   advance;

   assign timed   = phase_timed(phase_q);
   assign advance = timed && sec_tick && sec_last;

   always_comb begin
      case (phase_q)
         PH_FWD:     limit = CW'(FWD_SECS);
         PH_PAUSE_A: limit = CW'(PAUSE_A_SECS);
         PH_REV:     limit = CW'(REV_SECS);
         PH_PAUSE_B: limit = CW'(PAUSE_B_SECS);
         default:    limit = CW'(1);
      endcase
   end

   always_comb begin
      phase_d = phase_q;
      if (!run_en)
         phase_d = PH_IDLE;
      else if (timer_done)
         phase_d = PH_HALT;
      else if (phase_q == PH_IDLE)
         phase_d = PH_FWD;
      else if (advance)
         phase_d = phase_after(phase_q);
   end

   assign cnt_clear = !run_en || timer_done || !timed || advance;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase_q <= PH_IDLE;
      else
         phase_q <= phase_d;
   end

   assign phase = phase_q;

endmodule

// File: rtl/wds_output_map.sv
module wds_output_map
   import wds_pkg::*;
#(
   parameter bit LAMP_ACTIVE_LOW = 1'b0
) (
   input  phase_e phase,
   output logic   motor_fwd,
   output logic   motor_rev,
   output logic   lamp_fwd,
   output logic   lamp_rev,
   output logic   lamp_pause
);

   logic on_fwd, on_rev, on_pause;

   assign on_fwd   = (phase == PH_FWD);
   assign on_rev   = (phase == PH_REV);
   assign on_pause = (phase == PH_PAUSE_A) || (phase == PH_PAUSE_B);

   assign motor_fwd = on_fwd;
   assign motor_rev = on_rev;

   generate
      if (LAMP_ACTIVE_LOW) begin : g_lamp_low
         assign lamp_fwd   = !on_fwd;
         assign lamp_rev   = !on_rev;
         assign lamp_pause = !on_pause;
      end else begin : g_lamp_high
         assign lamp_fwd   = on_fwd;
         assign lamp_rev   = on_rev;
         assign lamp_pause = on_pause;
      end
   endgenerate

endmodule

// File: rtl/wash_drum_sequencer.sv
module wash_drum_sequencer #(
   parameter int FWD_SECS        = 20,
   parameter int PAUSE_A_SECS    = 10,
   parameter int REV_SECS        = 20,
   parameter int PAUSE_B_SECS    = 10,
   parameter bit LAMP_ACTIVE_LOW = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sec_tick,
   input  logic run_en,
   input  logic timer_done,
   output logic motor_fwd,
   output logic motor_rev,
   output logic lamp_fwd,
   output logic lamp_rev,
   output logic lamp_pause
);

   localparam int TURN_MAX  = (FWD_SECS > REV_SECS) ? FWD_SECS : REV_SECS;
   localparam int REST_MAX  = (PAUSE_A_SECS > PAUSE_B_SECS) ? PAUSE_A_SECS : PAUSE_B_SECS;
   localparam int STEP_MAX  = (TURN_MAX > REST_MAX) ? TURN_MAX : REST_MAX;
   localparam int CW        = $clog2(STEP_MAX + 1);

   generate
      if (FWD_SECS < 1 || PAUSE_A_SECS < 1 || REV_SECS < 1 || PAUSE_B_SECS < 1) begin : g_bad_len
         $error("wash_drum_sequencer: every step length must be at least one second");
      end
   endgenerate

   wds_pkg::phase_e phase;
   logic            cnt_clear;
   logic            sec_last;
   logic [CW-1:0]   limit;

   wds_phase_fsm #(
      .CW           (CW),
      .FWD_SECS     (FWD_SECS),
      .PAUSE_A_SECS (PAUSE_A_SECS),
      .REV_SECS     (REV_SECS),
      .PAUSE_B_SECS (PAUSE_B_SECS)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_en     (run_en),
      .timer_done (timer_done),
      .sec_tick   (sec_tick),
      .sec_last   (sec_last),
      .phase      (phase),
      .cnt_clear  (cnt_clear),
      .limit      (limit)
   );

   wds_sec_counter #(
      .CW (CW)
   ) u_secs (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (cnt_clear),
      .tick  (sec_tick),
      .limit (limit),
      .last  (sec_last)
   );

   wds_output_map #(
      .LAMP_ACTIVE_LOW (LAMP_ACTIVE_LOW)
   ) u_out (
      .phase      (phase),
      .motor_fwd  (motor_fwd),
      .motor_rev  (motor_rev),
      .lamp_fwd   (lamp_fwd),
      .lamp_rev   (lamp_rev),
      .lamp_pause (lamp_pause)
   );

endmodule

// File: rtl/wds_checks.sv
module wds_checks #(
   parameter bit LAMP_ACTIVE_LOW = 1'b0
) (
   input logic clk,
   input logic rst_n,
   input logic sec_tick,
   input logic run_en,
   input logic timer_done,
   input logic motor_fwd,
   input logic motor_rev,
   input logic lamp_fwd,
   input logic lamp_rev,
   input logic lamp_pause
);

   logic lf, lr, lp, any_on;
   assign lf     = lamp_fwd   ^ LAMP_ACTIVE_LOW;
   assign lr     = lamp_rev   ^ LAMP_ACTIVE_LOW;
   assign lp     = lamp_pause ^ LAMP_ACTIVE_LOW;
   assign any_on = motor_fwd || motor_rev || lf || lr || lp;

   assert_motor_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(motor_fwd && motor_rev));

   assert_pause_still_R5: assert property (@(posedge clk) disable iff (!rst_n)
      lp |-> (!motor_fwd && !motor_rev));

   assert_lamp_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lf, lr, lp}) && (lf == motor_fwd) && (lr == motor_rev));

   assert_expiry_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && timer_done) |=> !any_on);

   assert_run_low_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> !any_on);

   assert_hold_no_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !timer_done && !sec_tick && (motor_fwd || motor_rev || lp))
      |=> $stable({motor_fwd, motor_rev, lp}));

endmodule

bind wash_drum_sequencer wds_checks #(
   .LAMP_ACTIVE_LOW (LAMP_ACTIVE_LOW)
) u_wds_checks (
   .clk        (clk),
   .rst_n      (rst_n),
   .sec_tick   (sec_tick),
   .run_en     (run_en),
   .timer_done (timer_done),
   .motor_fwd  (motor_fwd),
   .motor_rev  (motor_rev),
   .lamp_fwd   (lamp_fwd),
   .lamp_rev   (lamp_rev),
   .lamp_pause (lamp_pause)
);

// File: tb/wash_drum_sequencer_test.sv
`timescale 1ns/1ps
module wash_drum_sequencer_test;

   localparam int T_FWD = 4;
   localparam int T_PA  = 2;
   localparam int T_REV = 3;
   localparam int T_PB  = 1;

   // observed vector: {motor_fwd, motor_rev, lamp_fwd, lamp_rev, lamp_pause}
   localparam logic [4:0] E_FWD = 5'b10100;
   localparam logic [4:0] E_REV = 5'b01010;
   localparam logic [4:0] E_PAU = 5'b00001;
   localparam logic [4:0] E_OFF = 5'b00000;

   logic clk = 1'b0;
   logic rst_n = 1'b1;
   logic sec_tick = 1'b0;
   logic run_en = 1'b0;
   logic timer_done = 1'b0;
   logic motor_fwd, motor_rev, lamp_fwd, lamp_rev, lamp_pause;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   logic [4:0] q_exp[$];
   string      q_tag[$];

   always #10 clk = ~clk;

   wash_drum_sequencer #(
      .FWD_SECS     (T_FWD),
      .PAUSE_A_SECS (T_PA),
      .REV_SECS     (T_REV),
      .PAUSE_B_SECS (T_PB)
   ) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .sec_tick   (sec_tick),
      .run_en     (run_en),
      .timer_done (timer_done),
      .motor_fwd  (motor_fwd),
      .motor_rev  (motor_rev),
      .lamp_fwd   (lamp_fwd),
      .lamp_rev   (lamp_rev),
      .lamp_pause (lamp_pause)
   );

   wire [4:0] seen = {motor_fwd, motor_rev, lamp_fwd, lamp_rev, lamp_pause};

   task automatic compare(input logic [4:0] exp, input string tag);
      n_checks++;
      if (seen !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b at %0t", tag, seen, exp, $time);
      end
   endtask

   // monitor: pops one expectation per cycle, away from the active edge
   always @(negedge clk) begin
      if (q_exp.size() > 0) begin
         logic [4:0] e;
         string      t;
         e = q_exp.pop_front();
         t = q_tag.pop_front();
         compare(e, t);
      end
   end

   // driver: one cycle of stimulus, expectation for the state after that edge
   task automatic step(input logic tk, input logic rn, input logic dn,
                       input logic [4:0] exp, input string tag);
      @(negedge clk);
      sec_tick   = tk;
      run_en     = rn;
      timer_done = dn;
      @(posedge clk);
      #1;
      q_exp.push_back(exp);
      q_tag.push_back(tag);
   endtask

   // full step with idle cycles between ticks
   task automatic do_phase(input int n, input logic [4:0] cur, input logic [4:0] nxt,
                           input string tag);
      for (int i = 0; i < n - 1; i++) begin
         step(1'b1, 1'b1, 1'b0, cur, tag);
         step(1'b0, 1'b1, 1'b0, cur, tag);
      end
      step(1'b1, 1'b1, 1'b0, nxt, tag);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 20);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      compare(E_OFF, "R1 reset");
      run_en = 1'b1;
      sec_tick = 1'b1;
      @(negedge clk);
      compare(E_OFF, "R1 reset held with run");
      run_en = 1'b0;
      sec_tick = 1'b0;
      rst_n = 1'b1;

      // start and one full cycle
      step(1'b0, 1'b1, 1'b0, E_FWD, "R2 start");
      do_phase(T_FWD, E_FWD, E_PAU, "R2 R3 forward length");
      do_phase(T_PA,  E_PAU, E_REV, "R3 R5 first pause");
      do_phase(T_REV, E_REV, E_PAU, "R3 R6 reverse");
      do_phase(T_PB,  E_PAU, E_FWD, "R4 loop back");
      do_phase(T_FWD, E_FWD, E_PAU, "R4 second forward");
      do_phase(T_PA,  E_PAU, E_REV, "R3 second pause A");

      // expiry mid reverse
      step(1'b1, 1'b1, 1'b0, E_REV, "R3 reverse");
      step(1'b0, 1'b1, 1'b1, E_OFF, "R7 expiry");
      step(1'b1, 1'b1, 1'b0, E_OFF, "R7 stays halted");
      step(1'b1, 1'b1, 1'b0, E_OFF, "R9 tick in halt");
      step(1'b0, 1'b0, 1'b0, E_OFF, "R8 run low");
      step(1'b0, 1'b1, 1'b0, E_FWD, "R8 restart");
      do_phase(T_FWD, E_FWD, E_PAU, "R8 full forward after restart");
      do_phase(T_PA,  E_PAU, E_REV, "R3 pause A");

      // run withdrawn mid reverse, ticks ignored while idle
      step(1'b1, 1'b1, 1'b0, E_REV, "R3 reverse");
      step(1'b0, 1'b0, 1'b0, E_OFF, "R8 run drop");
      step(1'b1, 1'b0, 1'b0, E_OFF, "R9 tick in idle");
      step(1'b1, 1'b0, 1'b0, E_OFF, "R9 tick in idle");
      step(1'b0, 1'b1, 1'b0, E_FWD, "R2 start again");
      for (int i = 0; i < 5; i++)
         step(1'b0, 1'b1, 1'b0, E_FWD, "R9 no tick hold");
      do_phase(T_FWD, E_FWD, E_PAU, "R9 forward count");
      do_phase(T_PA,  E_PAU, E_REV, "R3 pause A");
      do_phase(T_REV, E_REV, E_PAU, "R3 reverse");

      // expiry on the tick that ends the second pause
      step(1'b1, 1'b1, 1'b1, E_OFF, "R7 expiry beats boundary");
      step(1'b1, 1'b1, 1'b0, E_OFF, "R7 halt after flag clears");
      step(1'b0, 1'b0, 1'b0, E_OFF, "R8 idle");

      // run dropped on the tick that ends forward
      step(1'b0, 1'b1, 1'b0, E_FWD, "R2 start");
      for (int i = 0; i < T_FWD - 1; i++)
         step(1'b1, 1'b1, 1'b0, E_FWD, "R3 back-to-back ticks");
      step(1'b1, 1'b0, 1'b0, E_OFF, "R8 run low beats boundary");

      // reset during forward, then full forward again
      step(1'b0, 1'b1, 1'b0, E_FWD, "R2 start");
      step(1'b1, 1'b1, 1'b0, E_FWD, "R3 forward");
      step(1'b1, 1'b1, 1'b0, E_FWD, "R3 forward");
      @(negedge clk);
      sec_tick = 1'b0;
      rst_n = 1'b0;
      #2;
      compare(E_OFF, "R1 reset mid run");
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b0, 1'b1, 1'b0, E_FWD, "R8 start after reset");
      do_phase(T_FWD, E_FWD, E_PAU, "R8 full forward after reset");

      step(1'b0, 1'b0, 1'b0, E_OFF, "R8 final idle");
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule